// File: doc/BRIEF.md
# NAND Flash Read-Only Device Responder

This block plays the device side of a small-page NAND flash bus for two independent dies, and it serves reads only. The host shares one 8-bit data bus between the dies. Each die has an active-low chip enable. The host also drives active-low read and write strobes and active-high command and address latch enables. Every bus input is sampled in the block's clock domain, and strobe edges are found from two successive samples.

A die is told which area of its 528-byte page to use by one of three read commands. It then takes three address bytes and builds a byte pointer from them. Each read strobe returns the byte at the pointer, and the pointer steps forward when the strobe ends. Pages and blocks are crossed without wrap. A small internal array backs the low end of each die's address space, and that array holds 0xFF after reset. A preload port fills the array, much as an image is placed into the flash before use. Addresses beyond the array read as erased. Each die signals ready whenever it is selected and both strobes are idle. A die is never busy. Protocol misuse sets a sticky error flag for that die.

Top module: `nand_rd_resp`

## Requirements
- R1: After reset every array byte reads 0xFF, the error flags are 0, bus_doe is 0 and the rdy lines are 0 while no die is selected.
- R2: The command byte 0x00, 0x01 or 0x50, latched with cle, selects a read mode. The first address byte that follows sets the pointer to that byte plus a column base of 0x000, 0x100 or 0x200 respectively, and the address-cycle count starts over.
- R3: The second address byte adds byte×135168 (528×256) to the pointer. The third adds byte×528.
- R4: While the selected die's read strobe is low, bus_doe is 1 and bus_dout shows the byte at the pointer. The pointer increments once per strobe, and reads cross 528-byte page boundaries without wrap. A pointer at or beyond PAGE_BYTES×ARRAY_PAGES reads 0xFF.
- R5: When ce_n[0] is low, die 0 is selected whatever ce_n[1] is. ce_n[1] low alone selects die 1. With both high, strobes, commands and addresses change nothing, and bus_doe and rdy stay 0.
- R6: When the selected die sees both strobes high, its rdy bit is 1 and bus_doe is 0. No other rdy bit is 1.
- R7: Command 0xFF returns the die to idle.
- R8: An address byte that arrives in idle, or a fourth address byte, leaves the pointer unchanged and sets err for that die. err stays set until reset.
- R9: A command byte other than 0x00, 0x01, 0x50 and 0xFF sets err and leaves the die idle.
- R10: Command and address bytes are taken at the rising edge of we_n, using the cle, ale and data values held while we_n was low. cle takes priority over ale. A write strobe with neither latch enable high changes nothing.
- R11: A cycle with ld_en high writes ld_data into die ld_die at array index ld_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | N_DIE | Active-low chip enables, one per die |
| re_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| bus_din | input | 8 | Command or address byte from the host |
| bus_dout | output | 8 | Read byte toward the host |
| bus_doe | output | 1 | Output enable for bus_dout |
| rdy | output | N_DIE | Per-die ready indication |
| err | output | N_DIE | Per-die sticky protocol-error flag |
| ld_en | input | 1 | Preload write enable |
| ld_die | input | DSW | Die that the preload targets |
| ld_addr | input | AW | Array index of the preload write |
| ld_data | input | 8 | Preload byte |

## Verification
The bench uses the defaults: two dies, 528-byte pages, a 256-page high stride and a two-page array of 1056 bytes per die. With a two-page array, a single third-cycle address byte of 1 moves a read across the seam between backed pages. The last backed byte at index 1055 sits next to the first unbacked one, and a second-cycle byte of 1 lands far outside the array. All three mode bases and both page offsets therefore fall inside the test reads, and distinct byte patterns per die show which die answered a read.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_RD3  = 2'd3
  } rd_mode_e;

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_AREA0 = 8'h00;
  localparam logic [7:0] CMD_AREA1 = 8'h01;
  localparam logic [7:0] CMD_AREA2 = 8'h50;

  localparam int unsigned AREA1_BASE = 32'h100;
  localparam int unsigned AREA2_BASE = 32'h200;

  typedef struct packed {
    logic       wr_cmd;
    logic       wr_adr;
    logic       rd_adv;
    logic [7:0] data;
  } bus_evt_t;

endpackage

// File: rtl/nfr_bus_sampler.sv
module nfr_bus_sampler
  import nfr_pkg::*;
#(
  parameter int N_DIE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DIE-1:0] ce_n,
  input  logic             re_n,
  input  logic             we_n,
  input  logic             cle,
  input  logic             ale,
  input  logic [7:0]       din,
  output bus_evt_t         evt,
  output logic [N_DIE-1:0] evt_sel,
  output logic [N_DIE-1:0] cur_sel,
  output logic             cur_re_n,
  output logic             cur_we_n
);

  logic [N_DIE-1:0] s_ce_n, p_ce_n;
  logic             s_re_n, p_re_n;
  logic             s_we_n, p_we_n;
  logic             s_cle, p_cle;
  logic             s_ale, p_ale;
  logic [7:0]       s_din, p_din;
  logic             smp_en;

  assign smp_en = 1'b1;

  // lowest-index enable wins
  function automatic logic [N_DIE-1:0] pick(input logic [N_DIE-1:0] cen);
    logic [N_DIE-1:0] r;
    r = '0;
    for (int i = N_DIE - 1; i >= 0; i--) begin
      if (!cen[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n <= '1;
      p_ce_n <= '1;
      s_re_n <= 1'b1;
      p_re_n <= 1'b1;
      s_we_n <= 1'b1;
      p_we_n <= 1'b1;
      s_cle  <= 1'b0;
      p_cle  <= 1'b0;
      s_ale  <= 1'b0;
      p_ale  <= 1'b0;
      s_din  <= '0;
      p_din  <= '0;
    end else if (smp_en) begin
      s_ce_n <= ce_n;
      p_ce_n <= s_ce_n;
      s_re_n <= re_n;
      p_re_n <= s_re_n;
      s_we_n <= we_n;
      p_we_n <= s_we_n;
      s_cle  <= cle;
      p_cle  <= s_cle;
      s_ale  <= ale;
      p_ale  <= s_ale;
      s_din  <= din;
      p_din  <= s_din;
    end
  end

  logic we_rise, re_rise;

  always_comb begin
    we_rise     = s_we_n & ~p_we_n;
    re_rise     = s_re_n & ~p_re_n;
    evt.wr_cmd  = we_rise & p_cle;
    evt.wr_adr  = we_rise & ~p_cle & p_ale;
    evt.rd_adv  = re_rise;
    evt.data    = p_din;
    evt_sel     = pick(p_ce_n);
    cur_sel     = pick(s_ce_n);
    cur_re_n    = s_re_n;
    cur_we_n    = s_we_n;
  end

endmodule

// File: rtl/nfr_die_ctrl.sv
module nfr_die_ctrl
  import nfr_pkg::*;
#(
  parameter int PTR_W      = 26,
  parameter int PAGE_BYTES = 528,
  parameter int HI_PAGES   = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  bus_evt_t         evt,
  output logic [PTR_W-1:0] ptr,
  output logic             err
);

  localparam logic [PTR_W-1:0] LO_STRIDE = PTR_W'(PAGE_BYTES);
  localparam logic [PTR_W-1:0] HI_STRIDE = PTR_W'(PAGE_BYTES * HI_PAGES);
  localparam logic [1:0]       ACNT_DONE = 2'd3;

  rd_mode_e         st_q, st_d;
  logic [1:0]       acnt_q, acnt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             err_q, err_d;
  logic             upd_en;
  logic [PTR_W-1:0] byte_ext, col_base;

  always_comb begin
    byte_ext = PTR_W'(evt.data);
    case (st_q)
      ST_RD2:  col_base = PTR_W'(AREA1_BASE);
      ST_RD3:  col_base = PTR_W'(AREA2_BASE);
      default: col_base = '0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    acnt_d = acnt_q;
    ptr_d  = ptr_q;
    err_d  = err_q;
    if (evt.wr_cmd) begin
      case (evt.data)
        CMD_RESET: st_d = ST_IDLE;
        CMD_AREA0: begin st_d = ST_RD1; acnt_d = 2'd0; end
        CMD_AREA1: begin st_d = ST_RD2; acnt_d = 2'd0; end
        CMD_AREA2: begin st_d = ST_RD3; acnt_d = 2'd0; end
        default: begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      endcase
    end else if (evt.wr_adr) begin
      if (st_q == ST_IDLE || acnt_q == ACNT_DONE) begin
        err_d = 1'b1;
      end else begin
        case (acnt_q)
          2'd0:    ptr_d = col_base + byte_ext;
          2'd1:    ptr_d = ptr_q + byte_ext * HI_STRIDE;
          default: ptr_d = ptr_q + byte_ext * LO_STRIDE;
        endcase
        acnt_d = acnt_q + 2'd1;
      end
    end else if (evt.rd_adv) begin
      ptr_d = ptr_q + PTR_W'(1);
    end
  end

  assign upd_en = sel & (evt.wr_cmd | evt.wr_adr | evt.rd_adv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      acnt_q <= 2'd0;
      ptr_q  <= '0;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      acnt_q <= acnt_d;
      ptr_q  <= ptr_d;
      err_q  <= err_d;
    end
  end

  assign ptr = ptr_q;
  assign err = err_q;

endmodule

// File: rtl/nfr_array.sv
module nfr_array #(
  parameter int DEPTH = 1056,
  parameter int PTR_W = 26,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [7:0]       ld_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [7:0]       rd_data
);

  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);
  localparam logic [AW-1:0]    LD_LIMIT = AW'(DEPTH - 1);

  logic [7:0] mem [DEPTH];
  logic       wr_en;

  assign wr_en = ld_en && (ld_addr <= LD_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      mem[ld_addr] <= ld_data;
    end
  end

  always_comb begin
    if (rd_ptr < LIMIT) rd_data = mem[rd_ptr[AW-1:0]];
    else                rd_data = 8'hFF;
  end

endmodule

// File: rtl/nand_rd_resp.sv
module nand_rd_resp
  import nfr_pkg::*;
#(
  parameter int N_DIE       = 2,
  parameter int PAGE_BYTES  = 528,
  parameter int HI_PAGES    = 256,
  parameter int ARRAY_PAGES = 2,
  parameter int PTR_W       = 26,
  parameter int DEPTH       = PAGE_BYTES * ARRAY_PAGES,
  parameter int AW          = $clog2(DEPTH),
  parameter int DSW         = (N_DIE > 1) ? $clog2(N_DIE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DIE-1:0] ce_n,
  input  logic             re_n,
  input  logic             we_n,
  input  logic             cle,
  input  logic             ale,
  input  logic [7:0]       bus_din,
  output logic [7:0]       bus_dout,
  output logic             bus_doe,
  output logic [N_DIE-1:0] rdy,
  output logic [N_DIE-1:0] err,
  input  logic             ld_en,
  input  logic [DSW-1:0]   ld_die,
  input  logic [AW-1:0]    ld_addr,
  input  logic [7:0]       ld_data
);

  bus_evt_t         evt;
  logic [N_DIE-1:0] evt_sel, cur_sel;
  logic             cur_re_n, cur_we_n;
  logic [7:0]       die_rd [N_DIE];

  nfr_bus_sampler #(.N_DIE(N_DIE)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .re_n     (re_n),
    .we_n     (we_n),
    .cle      (cle),
    .ale      (ale),
    .din      (bus_din),
    .evt      (evt),
    .evt_sel  (evt_sel),
    .cur_sel  (cur_sel),
    .cur_re_n (cur_re_n),
    .cur_we_n (cur_we_n)
  );

  for (genvar d = 0; d < N_DIE; d++) begin : g_die
    logic [PTR_W-1:0] ptr;
    logic             ld_hit;

    assign ld_hit = ld_en && (ld_die == DSW'(d));

    nfr_die_ctrl #(
      .PTR_W      (PTR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .HI_PAGES   (HI_PAGES)
    ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (evt_sel[d]),
      .evt   (evt),
      .ptr   (ptr),
      .err   (err[d])
    );

    nfr_array #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W),
      .AW    (AW)
    ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_hit),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .rd_ptr  (ptr),
      .rd_data (die_rd[d])
    );
  end

  always_comb begin
    bus_dout = '0;
    for (int d = 0; d < N_DIE; d++) begin
      if (cur_sel[d] && !cur_re_n) bus_dout = bus_dout | die_rd[d];
    end
    bus_doe = (|cur_sel) & ~cur_re_n;
    rdy     = cur_sel & {N_DIE{cur_re_n & cur_we_n}};
  end

endmodule

// File: rtl/nfr_chk.sv
module nfr_chk #(
  parameter int N_DIE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DIE-1:0] ce_n,
  input logic             re_n,
  input logic             we_n,
  input logic             bus_doe,
  input logic [N_DIE-1:0] rdy,
  input logic [N_DIE-1:0] err
);

  // R4/R6: data is driven only after a sampled low read strobe
  a_r6_doe_after_re: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !$past(re_n));

  // R5: no output enable without a chip enable
  a_r5_doe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !(&$past(ce_n)));

  // R6: ready only with both strobes idle
  a_r6_rdy_strobes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|rdy) |-> ($past(re_n) && $past(we_n)));

  // R6: at most one die reports ready
  a_r6_rdy_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rdy));

  // R6: ready and driven data never together
  a_r6_rdy_doe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_doe && (|rdy)));

  // R8: error flags never clear outside reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((err & $past(err)) == $past(err)));

  if (N_DIE > 1) begin : g_prio
    // R5: die 1 only answers when die 0 is not enabled
    a_r5_prio: assert property (@(posedge clk) disable iff (!rst_n)
      rdy[1] |-> $past(ce_n[0]));
  end

endmodule

bind nand_rd_resp nfr_chk #(.N_DIE(N_DIE)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .re_n    (re_n),
  .we_n    (we_n),
  .bus_doe (bus_doe),
  .rdy     (rdy),
  .err     (err)
);

// File: tb/nand_rd_resp_tb_top.sv
module nand_rd_resp_tb_top;

  localparam int DEPTH = 1056;

  logic       clk;
  logic       rst_n;
  logic [1:0] ce_n;
  logic       re_n, we_n, cle, ale;
  logic [7:0] bus_din;
  logic [7:0] bus_dout;
  logic       bus_doe;
  logic [1:0] rdy, err;
  logic       ld_en;
  logic [0:0] ld_die;
  logic [10:0] ld_addr;
  logic [7:0] ld_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  nand_rd_resp dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
    .cle(cle), .ale(ale), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .rdy(rdy), .err(err), .ld_en(ld_en),
    .ld_die(ld_die), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int die, input int idx);
    if (idx >= DEPTH) return 8'hFF;
    if (die == 0) return 8'(idx) ^ 8'h5A;
    return 8'(idx * 7) ^ 8'hC3;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    @(posedge clk); #1;
    rst_n = 1'b0; ce_n = 2'b11; re_n = 1'b1; we_n = 1'b1;
    cle = 1'b0; ale = 1'b0; bus_din = '0;
    ld_en = 1'b0; ld_die = '0; ld_addr = '0; ld_data = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic bus_wr(input logic [1:0] cen, input logic c, input logic a,
                        input logic [7:0] d);
    ce_n = cen; cle = c; ale = a; bus_din = d;
    step(2);
    we_n = 1'b0;
    step(3);
    we_n = 1'b1;
    step(3);
    cle = 1'b0; ale = 1'b0;
    step(1);
  endtask

  task automatic rd(input logic [1:0] cen, output logic [7:0] d, output logic oe);
    ce_n = cen;
    step(1);
    re_n = 1'b0;
    step(3);
    @(negedge clk);
    d  = bus_dout;
    oe = bus_doe;
    @(posedge clk); #1;
    re_n = 1'b1;
    step(4);
  endtask

  task automatic set_addr(input logic [1:0] cen, input logic [7:0] cmd,
                          input logic [7:0] col, input logic [7:0] hi,
                          input logic [7:0] lo);
    bus_wr(cen, 1'b1, 1'b0, cmd);
    bus_wr(cen, 1'b0, 1'b1, col);
    bus_wr(cen, 1'b0, 1'b1, hi);
    bus_wr(cen, 1'b0, 1'b1, lo);
  endtask

  task automatic expect_rd(input string req, input logic [1:0] cen, input logic [7:0] exp);
    logic [7:0] d;
    logic       oe;
    rd(cen, d, oe);
    chk({req, " data"}, d, exp);
    chk({req, " doe"}, {7'd0, oe}, 8'd1);
  endtask

  task automatic preload;
    for (int die = 0; die < 2; die++) begin
      for (int i = 0; i < DEPTH; i++) begin
        ld_en = 1'b1; ld_die = 1'(die); ld_addr = 11'(i); ld_data = pat(die, i);
        step(1);
      end
    end
    ld_en = 1'b0;
    step(1);
  endtask

  // R1, R6
  task automatic t_reset_state;
    @(negedge clk);
    chk("R1 doe after reset", {7'd0, bus_doe}, 8'd0);
    chk("R1 rdy unselected", {6'd0, rdy}, 8'd0);
    chk("R1 err after reset", {6'd0, err}, 8'd0);
    ce_n = 2'b10;
    step(3);
    @(negedge clk);
    chk("R6 rdy die0 idle", {6'd0, rdy}, 8'd1);
    chk("R6 doe idle", {7'd0, bus_doe}, 8'd0);
    set_addr(2'b10, 8'h00, 8'd0, 8'd0, 8'd0);
    expect_rd("R1 erased byte", 2'b10, 8'hFF);
  endtask

  // R2, R4, R11
  task automatic t_modes;
    set_addr(2'b10, 8'h00, 8'd5, 8'd0, 8'd0);
    for (int k = 0; k < 3; k++) expect_rd("R2 R4 R11 area0 stream", 2'b10, pat(0, 5 + k));
    set_addr(2'b10, 8'h01, 8'h10, 8'd0, 8'd0);
    expect_rd("R2 area1 base", 2'b10, pat(0, 'h110));
    set_addr(2'b10, 8'h50, 8'h0E, 8'd0, 8'd0);
    for (int k = 0; k < 3; k++) expect_rd("R2 R4 area2 page cross", 2'b10, pat(0, 'h20E + k));
  endtask

  // R3, R4
  task automatic t_strides;
    set_addr(2'b10, 8'h00, 8'd3, 8'd0, 8'd1);
    expect_rd("R3 low stride", 2'b10, pat(0, 531));
    set_addr(2'b10, 8'h50, 8'h0F, 8'd0, 8'd1);
    expect_rd("R4 last backed byte", 2'b10, pat(0, 1055));
    expect_rd("R4 beyond array", 2'b10, 8'hFF);
    set_addr(2'b10, 8'h00, 8'd0, 8'd1, 8'd0);
    expect_rd("R3 high stride", 2'b10, 8'hFF);
  endtask

  // R5
  task automatic t_select;
    logic [7:0] d;
    logic       oe;
    set_addr(2'b01, 8'h00, 8'd9, 8'd0, 8'd0);
    expect_rd("R5 die1 first", 2'b01, pat(1, 9));
    expect_rd("R5 die1 second", 2'b01, pat(1, 10));
    set_addr(2'b00, 8'h00, 8'h20, 8'd0, 8'd0);
    expect_rd("R5 both low picks die0", 2'b00, pat(0, 'h20));
    expect_rd("R5 die1 untouched", 2'b01, pat(1, 11));
    set_addr(2'b11, 8'h00, 8'h40, 8'd0, 8'd0);
    rd(2'b11, d, oe);
    chk("R5 none selected doe", {7'd0, oe}, 8'd0);
    @(negedge clk);
    chk("R5 none selected rdy", {6'd0, rdy}, 8'd0);
    expect_rd("R5 die0 ignored traffic", 2'b10, pat(0, 'h21));
    chk("R5 no err from unselected", {6'd0, err}, 8'd0);
  endtask

  // R10
  task automatic t_latch;
    bus_wr(2'b10, 1'b0, 1'b0, 8'h90);
    chk("R10 plain write no err", {6'd0, err}, 8'd0);
    expect_rd("R10 plain write no effect", 2'b10, pat(0, 'h22));
    bus_wr(2'b10, 1'b1, 1'b1, 8'h01);
    bus_wr(2'b10, 1'b0, 1'b1, 8'h05);
    bus_wr(2'b10, 1'b0, 1'b1, 8'h00);
    bus_wr(2'b10, 1'b0, 1'b1, 8'h00);
    expect_rd("R10 cle priority", 2'b10, pat(0, 'h105));
  endtask

  // R7, R8
  task automatic t_errors;
    set_addr(2'b01, 8'h00, 8'd2, 8'd0, 8'd0);
    bus_wr(2'b01, 1'b0, 1'b1, 8'h77);
    chk("R8 fourth addr err", {6'd0, err}, 8'd2);
    expect_rd("R8 fourth addr ignored", 2'b01, pat(1, 2));
    bus_wr(2'b10, 1'b1, 1'b0, 8'h00);
    bus_wr(2'b10, 1'b0, 1'b1, 8'd1);
    bus_wr(2'b10, 1'b1, 1'b0, 8'hFF);
    chk("R7 reset cmd no err", {6'd0, err}, 8'd2);
    bus_wr(2'b10, 1'b0, 1'b1, 8'h33);
    chk("R7 R8 addr in idle err", {6'd0, err}, 8'd3);
    expect_rd("R7 addr in idle ignored", 2'b10, pat(0, 1));
    bus_wr(2'b01, 1'b1, 1'b0, 8'h00);
    chk("R8 err sticky", {6'd0, err}, 8'd3);
  endtask

  // R9, R1
  task automatic t_unknown;
    do_reset();
    chk("R1 err cleared by reset", {6'd0, err}, 8'd0);
    bus_wr(2'b10, 1'b1, 1'b0, 8'h90);
    chk("R9 unknown cmd err", {6'd0, err}, 8'd1);
    bus_wr(2'b10, 1'b0, 1'b1, 8'h10);
    expect_rd("R9 idle after unknown", 2'b10, 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    preload();
    t_modes();
    t_strides();
    t_select();
    t_latch();
    t_errors();
    t_unknown();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule